// File: doc/BRIEF.md
# Line Read Request and Response Engine

This block turns read requests from a level-one cache or a DMA engine into one-flit read commands and gathers the matching response flits back into a line-sized buffer. Each request names an address, whether it fetches instructions or data, and whether the target is cacheable. A cacheable request fetches the whole aligned line. A non-cacheable request fetches one word.

Several reads may be in flight together. Each gets a slot in a small table of outstanding reads, and the slot index is sent as the transaction id. A response flit reaches a slot only when both its transaction id and its type tag match the slot. The flit marked end-of-packet closes the slot. One cycle later the block reports completion with the filled line, a mask of the words written and the combined error flag.

Top module: `line_read_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1, cmd_valid is 0 and done_valid is 0.
- R2: cmd_pktid bit 0 is the cacheable flag and bit 1 is the instruction flag. Bit 2 and bit 3 are always 0, so 000 means non-cacheable data, 001 cacheable data, 010 non-cacheable instruction and 011 cacheable instruction.
- R3: A cacheable request issues cmd_addr with the low log2(line bytes) bits cleared (6 bits with the defaults) and cmd_plen equal to the line size in bytes (64 with the defaults).
- R4: A non-cacheable request issues cmd_addr with the byte-in-word bits cleared (2 bits with the defaults) and cmd_plen equal to one word in bytes (4).
- R5: An accepted request appears on the command outputs in the next cycle. Its cmd_trdid is the lowest-numbered free slot. The command holds all of its fields stable until a cycle in which cmd_ready is 1.
- R6: req_ready is 0, and no request is accepted, while every slot is outstanding or while a command waits with cmd_ready at 0.
- R7: Accepted response flits fill consecutive words of the slot's line. A cacheable read starts at word 0. A non-cacheable read starts at the requested word index (address bits [5:2] with the defaults). Words that are never written read as zero.
- R8: One cycle after the accepted end-of-packet flit, done_valid pulses for one cycle. It carries the slot's transaction id, the instruction and cacheable flags, the line and the word mask. The slot becomes free.
- R9: done_err is 1 when any accepted flit of the transaction had rsp_err set.
- R10: A response flit is ignored when its slot is not outstanding or when rsp_pktid bits [2:0] differ from the slot's type code. rsp_pktid bit 3 is not compared.
- R11: Flits that arrive after the last word of the line has been filled are dropped. The offset does not wrap.
- R12: Flits of different outstanding transactions may interleave in any order. Each fills only its own slot's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low, synchronous |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data |
| req_cached | input | 1 | 1 = cacheable full-line read, 0 = single word |
| req_addr | input | ADDR_W | Byte address of the request |
| cmd_valid | output | 1 | Command flit present |
| cmd_ready | input | 1 | Network takes the command flit |
| cmd_addr | output | ADDR_W | Aligned command address |
| cmd_plen | output | PLEN_W | Burst length in bytes |
| cmd_trdid | output | TID_W | Transaction id (slot index) |
| cmd_pktid | output | 4 | Read type tag |
| rsp_valid | input | 1 | Response flit present (always taken) |
| rsp_trdid | input | TID_W | Response transaction id |
| rsp_pktid | input | 4 | Response type tag |
| rsp_data | input | DATA_W | Response word |
| rsp_eop | input | 1 | Last flit of the response packet |
| rsp_err | input | 1 | Error flag of this flit |
| done_valid | output | 1 | Completion pulse |
| done_trdid | output | TID_W | Slot that completed |
| done_instr | output | 1 | Instruction flag of the completed read |
| done_cached | output | 1 | Cacheable flag of the completed read |
| done_err | output | 1 | Combined error of the transaction |
| done_mask | output | LINE_WORDS | Words written in done_line |
| done_line | output | LINE_WORDS*DATA_W | Gathered line, word 0 in the low bits |

## Verification
A slot whose valid bit, type or fill offset is wrong shows up at the ports on the completion of that same transaction. It surfaces as a missing or extra done pulse, a word in the wrong place of done_line, or a wrong done_mask. It can also show as a wrong req_ready or cmd_trdid on the next request that looks for a free slot. The bench interleaves flits of up to four transactions at random and adds stray flits with wrong ids or tags. A slot that takes another slot's flits, or keeps flits it should drop, therefore shows within the completion of the transactions involved.

// File: rtl/lre_pkg.sv
package lre_pkg;

   typedef enum logic [2:0] {
      LRE_UNC_DATA  = 3'b000,
      LRE_CAC_DATA  = 3'b001,
      LRE_UNC_INSTR = 3'b010,
      LRE_CAC_INSTR = 3'b011
   } lre_kind_e;

   function automatic logic [2:0] lre_kind(input logic instr, input logic cached);
      return {1'b0, instr, cached};
   endfunction

endpackage

// File: rtl/lre_cmd_issue.sv
module lre_cmd_issue #(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int LINE_BYTES = 64,
   parameter int TID_W      = 2,
   parameter int PLEN_W     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              req_instr,
   input  logic              req_cached,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TID_W-1:0]  alloc_tid,
   input  logic              cmd_ready,
   output logic              cmd_valid,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [PLEN_W-1:0] cmd_plen,
   output logic [TID_W-1:0]  cmd_trdid,
   output logic [3:0]        cmd_pktid,
   output logic              cmd_stall
);
   import lre_pkg::*;

   localparam logic [ADDR_W-1:0] WORD_MASK = ~(ADDR_W'(WORD_BYTES) - 1'b1);
   localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES) - 1'b1);

   logic [ADDR_W-1:0] addr_al;
   logic [PLEN_W-1:0] plen_d;

   always_comb begin
      if (req_cached) begin
         addr_al = req_addr & LINE_MASK;
         plen_d  = PLEN_W'(LINE_BYTES);
      end else begin
         addr_al = req_addr & WORD_MASK;
         plen_d  = PLEN_W'(WORD_BYTES);
      end
   end

   assign cmd_stall = cmd_valid && !cmd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_addr  <= '0;
         cmd_plen  <= '0;
         cmd_trdid <= '0;
         cmd_pktid <= '0;
      end else if (accept) begin
         cmd_valid <= 1'b1;
         cmd_addr  <= addr_al;
         cmd_plen  <= plen_d;
         cmd_trdid <= alloc_tid;
         cmd_pktid <= {1'b0, lre_kind(req_instr, req_cached)};
      end else if (cmd_ready) begin
         cmd_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/lre_track_entry.sv
module lre_track_entry #(
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 16,
   parameter int TID_W      = 2,
   parameter int SLOT       = 0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               alloc,
   input  logic [2:0]                         alloc_kind,
   input  logic [$clog2(LINE_WORDS)-1:0]      alloc_off,
   input  logic                               rsp_valid,
   input  logic [TID_W-1:0]                   rsp_trdid,
   input  logic [3:0]                         rsp_pktid,
   input  logic [DATA_W-1:0]                  rsp_data,
   input  logic                               rsp_eop,
   input  logic                               rsp_err,
   output logic                               busy,
   output logic [2:0]                         kind,
   output logic                               hit,
   output logic [LINE_WORDS*DATA_W-1:0]       line_nxt,
   output logic [LINE_WORDS-1:0]              mask_nxt,
   output logic                               err_nxt
);
   localparam int OFF_W = $clog2(LINE_WORDS);
   localparam logic [OFF_W:0] PTR_END = (OFF_W+1)'(LINE_WORDS);

   logic [LINE_WORDS-1:0][DATA_W-1:0] line_q, line_d;
   logic [LINE_WORDS-1:0]             mask_q, mask_d;
   logic [OFF_W:0]                    ptr_q;
   logic                              err_q;
   logic                              room;

   assign hit  = rsp_valid && busy && (rsp_trdid == TID_W'(SLOT)) && (rsp_pktid[2:0] == kind);
   assign room = ptr_q < PTR_END;

   always_comb begin
      line_d = line_q;
      mask_d = mask_q;
      if (hit && room) begin
         line_d[ptr_q[OFF_W-1:0]] = rsp_data;
         mask_d[ptr_q[OFF_W-1:0]] = 1'b1;
      end
   end

   assign line_nxt = line_d;
   assign mask_nxt = mask_d;
   assign err_nxt  = err_q || (hit && rsp_err);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         kind   <= '0;
         ptr_q  <= '0;
         line_q <= '0;
         mask_q <= '0;
         err_q  <= 1'b0;
      end else if (alloc) begin
         busy   <= 1'b1;
         kind   <= alloc_kind;
         ptr_q  <= {1'b0, alloc_off};
         line_q <= '0;
         mask_q <= '0;
         err_q  <= 1'b0;
      end else if (hit) begin
         line_q <= line_d;
         mask_q <= mask_d;
         err_q  <= err_nxt;
         if (room) ptr_q <= ptr_q + 1'b1;
         if (rsp_eop) busy <= 1'b0;
      end
   end

endmodule

// File: rtl/lre_cpl_mux.sv
module lre_cpl_mux #(
   parameter int NUM_TID    = 4,
   parameter int TID_W      = 2,
   parameter int LINE_WORDS = 16,
   parameter int LINE_W     = 512
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_TID-1:0]                   hit_vec,
   input  logic                                 rsp_eop,
   input  logic [NUM_TID-1:0][LINE_W-1:0]       lines,
   input  logic [NUM_TID-1:0][LINE_WORDS-1:0]   masks,
   input  logic [NUM_TID-1:0][2:0]              kinds,
   input  logic [NUM_TID-1:0]                   errs,
   output logic                                 done_valid,
   output logic [TID_W-1:0]                     done_trdid,
   output logic                                 done_instr,
   output logic                                 done_cached,
   output logic                                 done_err,
   output logic [LINE_WORDS-1:0]                done_mask,
   output logic [LINE_W-1:0]                    done_line
);
   logic [LINE_W-1:0]     sel_line;
   logic [LINE_WORDS-1:0] sel_mask;
   logic [2:0]            sel_kind;
   logic                  sel_err;
   logic [TID_W-1:0]      sel_tid;
   logic                  fire;

   always_comb begin
      sel_line = '0;
      sel_mask = '0;
      sel_kind = '0;
      sel_err  = 1'b0;
      sel_tid  = '0;
      for (int i = 0; i < NUM_TID; i++) begin
         if (hit_vec[i]) begin
            sel_line = sel_line | lines[i];
            sel_mask = sel_mask | masks[i];
            sel_kind = sel_kind | kinds[i];
            sel_err  = sel_err  | errs[i];
            sel_tid  = sel_tid  | TID_W'(i);
         end
      end
   end

   assign fire = (|hit_vec) && rsp_eop;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_valid  <= 1'b0;
         done_trdid  <= '0;
         done_instr  <= 1'b0;
         done_cached <= 1'b0;
         done_err    <= 1'b0;
         done_mask   <= '0;
         done_line   <= '0;
      end else begin
         done_valid <= fire;
         if (fire) begin
            done_trdid  <= sel_tid;
            done_instr  <= sel_kind[1];
            done_cached <= sel_kind[0];
            done_err    <= sel_err;
            done_mask   <= sel_mask;
            done_line   <= sel_line;
         end
      end
   end

endmodule

// File: rtl/line_read_engine.sv
module line_read_engine #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 16,
   parameter int NUM_TID    = 4,
   localparam int TID_W      = (NUM_TID > 1) ? $clog2(NUM_TID) : 1,
   localparam int OFF_W      = $clog2(LINE_WORDS),
   localparam int WORD_BYTES = DATA_W / 8,
   localparam int BOFF_W     = $clog2(WORD_BYTES),
   localparam int LINE_BYTES = LINE_WORDS * WORD_BYTES,
   localparam int PLEN_W     = $clog2(LINE_BYTES) + 1,
   localparam int LINE_W     = LINE_WORDS * DATA_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_instr,
   input  logic                  req_cached,
   input  logic [ADDR_W-1:0]     req_addr,
   output logic                  cmd_valid,
   input  logic                  cmd_ready,
   output logic [ADDR_W-1:0]     cmd_addr,
   output logic [PLEN_W-1:0]     cmd_plen,
   output logic [TID_W-1:0]      cmd_trdid,
   output logic [3:0]            cmd_pktid,
   input  logic                  rsp_valid,
   input  logic [TID_W-1:0]      rsp_trdid,
   input  logic [3:0]            rsp_pktid,
   input  logic [DATA_W-1:0]     rsp_data,
   input  logic                  rsp_eop,
   input  logic                  rsp_err,
   output logic                  done_valid,
   output logic [TID_W-1:0]      done_trdid,
   output logic                  done_instr,
   output logic                  done_cached,
   output logic                  done_err,
   output logic [LINE_WORDS-1:0] done_mask,
   output logic [LINE_W-1:0]     done_line
);
   import lre_pkg::*;

   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0)
      $error("LINE_WORDS must be a power of two of at least 2");
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0)
      $error("DATA_W must be a power of two of at least 8");
   if (NUM_TID < 1)
      $error("NUM_TID must be at least 1");
   if (ADDR_W < BOFF_W + OFF_W + 1)
      $error("ADDR_W too small for one line");

   logic [NUM_TID-1:0]                 entry_vld;
   logic [NUM_TID-1:0]                 hit_vec;
   logic [NUM_TID-1:0][2:0]            kinds;
   logic [NUM_TID-1:0][LINE_W-1:0]     lines;
   logic [NUM_TID-1:0][LINE_WORDS-1:0] masks;
   logic [NUM_TID-1:0]                 errs;
   logic [TID_W-1:0]                   alloc_tid;
   logic                               has_free;
   logic                               cmd_stall;
   logic                               accept;
   logic [OFF_W-1:0]                   start_off;
   logic [2:0]                         req_kind;

   always_comb begin
      alloc_tid = '0;
      has_free  = 1'b0;
      for (int i = NUM_TID - 1; i >= 0; i--) begin
         if (!entry_vld[i]) begin
            alloc_tid = TID_W'(i);
            has_free  = 1'b1;
         end
      end
   end

   assign req_ready = has_free && !cmd_stall;
   assign accept    = req_valid && req_ready;
   assign start_off = req_cached ? '0 : req_addr[BOFF_W +: OFF_W];
   assign req_kind  = lre_kind(req_instr, req_cached);

   lre_cmd_issue #(
      .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LINE_BYTES(LINE_BYTES),
      .TID_W(TID_W), .PLEN_W(PLEN_W)
   ) issue_i (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .req_instr(req_instr), .req_cached(req_cached), .req_addr(req_addr),
      .alloc_tid(alloc_tid), .cmd_ready(cmd_ready),
      .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_plen(cmd_plen),
      .cmd_trdid(cmd_trdid), .cmd_pktid(cmd_pktid), .cmd_stall(cmd_stall)
   );

   for (genvar g = 0; g < NUM_TID; g++) begin : g_slot
      lre_track_entry #(
         .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .TID_W(TID_W), .SLOT(g)
      ) entry_i (
         .clk(clk), .rst_n(rst_n),
         .alloc(accept && (alloc_tid == TID_W'(g))),
         .alloc_kind(req_kind), .alloc_off(start_off),
         .rsp_valid(rsp_valid), .rsp_trdid(rsp_trdid), .rsp_pktid(rsp_pktid),
         .rsp_data(rsp_data), .rsp_eop(rsp_eop), .rsp_err(rsp_err),
         .busy(entry_vld[g]), .kind(kinds[g]), .hit(hit_vec[g]),
         .line_nxt(lines[g]), .mask_nxt(masks[g]), .err_nxt(errs[g])
      );
   end

   lre_cpl_mux #(
      .NUM_TID(NUM_TID), .TID_W(TID_W), .LINE_WORDS(LINE_WORDS), .LINE_W(LINE_W)
   ) cpl_i (
      .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .rsp_eop(rsp_eop),
      .lines(lines), .masks(masks), .kinds(kinds), .errs(errs),
      .done_valid(done_valid), .done_trdid(done_trdid), .done_instr(done_instr),
      .done_cached(done_cached), .done_err(done_err), .done_mask(done_mask),
      .done_line(done_line)
   );

endmodule

// File: rtl/line_read_engine_chk.sv
module line_read_engine_chk #(
   parameter int ADDR_W     = 32,
   parameter int NUM_TID    = 4,
   parameter int TID_W      = 2,
   parameter int PLEN_W     = 7,
   parameter int WORD_BYTES = 4,
   parameter int LINE_BYTES = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               cmd_valid,
   input logic               cmd_ready,
   input logic [ADDR_W-1:0]  cmd_addr,
   input logic [PLEN_W-1:0]  cmd_plen,
   input logic [TID_W-1:0]   cmd_trdid,
   input logic [3:0]         cmd_pktid,
   input logic               rsp_valid,
   input logic               rsp_eop,
   input logic               done_valid,
   input logic [TID_W-1:0]   done_trdid,
   input logic [NUM_TID-1:0] entry_vld
);
   logic [NUM_TID-1:0] vld_d;

   always_ff @(posedge clk) begin
      if (!rst_n) vld_d <= '0;
      else        vld_d <= entry_vld;
   end

   // R2
   a_r2_pktid_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_pktid[3:2] == 2'b00));

   // R3
   a_r3_line_plen: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_pktid[0]) |->
         (cmd_plen == PLEN_W'(LINE_BYTES)) && ((cmd_addr & ADDR_W'(LINE_BYTES - 1)) == '0));

   // R4
   a_r4_word_plen: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_pktid[0]) |->
         (cmd_plen == PLEN_W'(WORD_BYTES)) && ((cmd_addr & ADDR_W'(WORD_BYTES - 1)) == '0));

   // R5
   a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_addr) && $stable(cmd_trdid) && $stable(cmd_pktid) && $stable(cmd_plen)));

   // R6
   a_r6_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(entry_vld) == NUM_TID) |-> !req_ready);

   a_r6_stall_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |-> !req_ready);

   // R8
   a_r8_done_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(rsp_valid && rsp_eop));

   // R10
   a_r10_done_from_busy_slot: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (vld_d[done_trdid] && !entry_vld[done_trdid]));

endmodule

bind line_read_engine line_read_engine_chk #(
   .ADDR_W(ADDR_W), .NUM_TID(NUM_TID), .TID_W(TID_W), .PLEN_W(PLEN_W),
   .WORD_BYTES(WORD_BYTES), .LINE_BYTES(LINE_BYTES)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_plen(cmd_plen),
   .cmd_trdid(cmd_trdid), .cmd_pktid(cmd_pktid), .rsp_valid(rsp_valid),
   .rsp_eop(rsp_eop), .done_valid(done_valid), .done_trdid(done_trdid),
   .entry_vld(entry_vld)
);

// File: tb/line_read_engine_tb_top.sv
module line_read_engine_tb_top;

   localparam int NT = 4;
   localparam int LW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_instr = 1'b0, req_cached = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready;
   logic        cmd_valid;
   logic        cmd_ready = 1'b1;
   logic [31:0] cmd_addr;
   logic [6:0]  cmd_plen;
   logic [1:0]  cmd_trdid;
   logic [3:0]  cmd_pktid;
   logic        rsp_valid = 1'b0;
   logic [1:0]  rsp_trdid = '0;
   logic [3:0]  rsp_pktid = '0;
   logic [31:0] rsp_data = '0;
   logic        rsp_eop = 1'b0, rsp_err = 1'b0;
   logic        done_valid, done_instr, done_cached, done_err;
   logic [1:0]  done_trdid;
   logic [15:0] done_mask;
   logic [511:0] done_line;

   int nchk = 0;
   int nerr = 0;

   bit          busy [NT];
   bit          e_instr [NT];
   bit          e_cached [NT];
   int          e_ptr [NT];
   bit          e_err [NT];
   logic [15:0] e_mask [NT];
   logic [31:0] e_line [NT][LW];
   int          rem [NT];

   always #5 clk = ~clk;

   line_read_engine dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_instr(req_instr),
      .req_cached(req_cached), .req_addr(req_addr),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_plen(cmd_plen), .cmd_trdid(cmd_trdid), .cmd_pktid(cmd_pktid),
      .rsp_valid(rsp_valid), .rsp_trdid(rsp_trdid), .rsp_pktid(rsp_pktid),
      .rsp_data(rsp_data), .rsp_eop(rsp_eop), .rsp_err(rsp_err),
      .done_valid(done_valid), .done_trdid(done_trdid), .done_instr(done_instr),
      .done_cached(done_cached), .done_err(done_err), .done_mask(done_mask),
      .done_line(done_line)
   );

   task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int i = 0; i < NT; i++) if (!busy[i]) return i;
      return -1;
   endfunction

   function automatic logic [2:0] kind_of(input int t);
      return {1'b0, e_instr[t], e_cached[t]};
   endfunction

   function automatic logic [511:0] flat_line(input int t);
      logic [511:0] v;
      for (int w = 0; w < LW; w++) v[w*32 +: 32] = e_line[t][w];
      return v;
   endfunction

   task automatic do_req(input bit instr, input bit cached, input logic [31:0] addr);
      int t;
      t = lowest_free();
      @(negedge clk);
      req_valid = 1'b1; req_instr = instr; req_cached = cached; req_addr = addr;
      #1;
      chk("R6 ready with free slot", req_ready, 1'b1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R5 cmd_valid after accept", cmd_valid, 1'b1);
      chk("R5 lowest free trdid", cmd_trdid, t[1:0]);
      chk("R2 pktid code", cmd_pktid, {2'b00, instr, cached});
      if (cached) begin
         chk("R3 line address", cmd_addr, addr & ~32'h3f);
         chk("R3 line plen", cmd_plen, 7'd64);
      end else begin
         chk("R4 word address", cmd_addr, addr & ~32'h3);
         chk("R4 word plen", cmd_plen, 7'd4);
      end
      busy[t] = 1'b1; e_instr[t] = instr; e_cached[t] = cached;
      e_ptr[t] = cached ? 0 : int'(addr[5:2]);
      e_err[t] = 1'b0; e_mask[t] = '0;
      for (int w = 0; w < LW; w++) e_line[t][w] = '0;
      rem[t] = cached ? LW : 1;
   endtask

   task automatic send_flit(input int t, input logic [3:0] pkt, input logic [31:0] d,
                            input bit eop, input bit err);
      bit hit;
      hit = busy[t] && (pkt[2:0] == kind_of(t));
      @(negedge clk);
      rsp_valid = 1'b1; rsp_trdid = t[1:0]; rsp_pktid = pkt;
      rsp_data = d; rsp_eop = eop; rsp_err = err;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_eop = 1'b0; rsp_err = 1'b0;
      if (hit) begin
         if (e_ptr[t] < LW) begin
            e_line[t][e_ptr[t]] = d;
            e_mask[t][e_ptr[t]] = 1'b1;
            e_ptr[t]++;
         end
         if (err) e_err[t] = 1'b1;
      end
      if (hit && eop) begin
         chk("R8 done pulse", done_valid, 1'b1);
         chk("R8 done trdid", done_trdid, t[1:0]);
         chk("R8 done flags", {done_instr, done_cached}, {e_instr[t], e_cached[t]});
         chk("R9 done err", done_err, e_err[t]);
         chk("R7 done mask", done_mask, e_mask[t]);
         chk("R7 R12 done line", done_line, flat_line(t));
         busy[t] = 1'b0;
         @(negedge clk);
         chk("R8 done single cycle", done_valid, 1'b0);
      end else begin
         chk("R10 no done without accepted eop", done_valid, 1'b0);
      end
   endtask

   task automatic serve(input int t);
      while (rem[t] > 0) begin
         send_flit(t, {1'b0, kind_of(t)}, $urandom, rem[t] == 1, 1'b0);
         rem[t]--;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NT; i++) busy[i] = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset ready", req_ready, 1'b1);
      chk("R1 reset cmd idle", cmd_valid, 1'b0);
      chk("R1 reset done idle", done_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 post reset idle", {req_ready, cmd_valid, done_valid}, 3'b100);

      // R4 R7: single uncached data word lands at word 9
      do_req(1'b0, 1'b0, 32'h1000_0027);
      send_flit(0, 4'b0000, 32'hA5A5_0009, 1'b1, 1'b0);

      // R3: cached instruction line
      do_req(1'b1, 1'b1, 32'h2000_0174);
      serve(0);

      // R10: stray flits ignored; bit 3 of pktid not compared
      do_req(1'b1, 1'b0, 32'h0000_0040);
      send_flit(0, 4'b0000, 32'hDEAD_0001, 1'b1, 1'b0);
      send_flit(1, 4'b0010, 32'hDEAD_0002, 1'b1, 1'b0);
      send_flit(0, 4'b1010, 32'h1234_5678, 1'b1, 1'b0);

      // R6: fill all slots, then a request is refused
      for (int i = 0; i < NT; i++) do_req(i[0], i[1], 32'h3000_0000 + 32'(i * 68));
      @(negedge clk);
      req_valid = 1'b1; req_cached = 1'b0; req_addr = 32'h4;
      #1;
      chk("R6 full refuses", req_ready, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R6 no command when full", cmd_valid, 1'b0);

      // R12: interleave slots 2 and 3 (both cached), then the rest
      while (rem[2] > 0 || rem[3] > 0) begin
         for (int t = 2; t < 4; t++) begin
            if (rem[t] > 0) begin
               send_flit(t, {1'b0, kind_of(t)}, $urandom, rem[t] == 1, 1'b0);
               rem[t]--;
            end
         end
      end
      serve(0);
      serve(1);

      // R9 and R11: error on a middle flit, 18 flits into a 16-word line
      do_req(1'b0, 1'b1, 32'h5000_0010);
      for (int k = 0; k < 18; k++)
         send_flit(0, 4'b0001, 32'hB000_0000 + 32'(k), k == 17, k == 5);

      // R5: command held while cmd_ready is low
      cmd_ready = 1'b0;
      do_req(1'b0, 1'b0, 32'h6000_0008);
      @(negedge clk);
      chk("R5 command held", {cmd_valid, cmd_trdid, cmd_addr}, {1'b1, 2'd0, 32'h6000_0008});
      chk("R6 stall refuses", req_ready, 1'b0);
      cmd_ready = 1'b1;
      @(negedge clk);
      chk("R5 command released", cmd_valid, 1'b0);
      serve(0);

      // random mix with interleaving and stray flits
      for (int r = 0; r < 30; r++) begin
         int n;
         n = 1 + int'($urandom % NT);
         for (int i = 0; i < n; i++)
            do_req($urandom % 2, $urandom % 2, $urandom);
         while (rem[0] + rem[1] + rem[2] + rem[3] > 0) begin
            int t;
            t = int'($urandom % NT);
            if (rem[t] > 0) begin
               if ($urandom % 10 == 0)
                  send_flit(t, {1'b0, kind_of(t) ^ 3'b001}, $urandom, 1'b1, 1'b0);
               send_flit(t, {1'($urandom % 2), kind_of(t)}, $urandom, rem[t] == 1,
                         ($urandom % 8) == 0);
               rem[t]--;
            end
         end
      end

      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule